// File: doc/BRIEF.md
# Interval-Based Voltage and Frequency Governor

This block picks the operating point of a processor core from a table of eight frequency and supply-voltage levels. It counts the cycles in which the core reports itself busy over fixed observation windows. At the end of each window it asks for one level more when the core was loaded. It asks for one level less when the core sat idle for longer than a programmable limit. An application can instead hold the governor at an explicit level. While that request is held it takes precedence over the window-based predictor and may jump several levels in one move.

Every move is sequenced so that the supply is never too low for the clock in use. On the way up the voltage code moves first and the clock code follows one settle period later. On the way down the clock code drops first and the voltage code follows. A second settle period then elapses before the new level is reported and another move may begin. A request that arrives during this lockout waits and is served once the lockout ends. The voltage code goes to an external regulator and the clock code to an external clock generator.

Level `l` is encoded as voltage code `V_BASE + V_STEP*l`. With the defaults that is 1..15 in 50 mV steps above 0.75 V, so 0.8 V to 1.5 V. The clock code is the target frequency in MHz, `F_MIN + floor((F_MAX-F_MIN)*l/(NUM_LEVELS-1))`, which gives 59 to 250.

Top module: `dvs_governor`

## Requirements
- R1: While and after reset, with no move yet, the level is RESET_LEVEL (0), the voltage code is 1, the clock code is 59 and the transition flag is low.
- R2: At level l (0..7) the settled voltage code is 1+2*l and the settled clock code is 59+floor(191*l/7), so level 7 gives 15 and 250.
- R3: When the number of busy cycles in one window of INTERVAL_LEN cycles is strictly greater than upThresh, the governor starts a move to the current level plus one.
- R4: When R3 does not apply and the number of idle cycles in the window is strictly greater than downThresh, the governor starts a move to the current level minus one; otherwise the level is held.
- R5: The level saturates: no move is started upward from level 7 or downward from level 0.
- R6: On a move to a higher level, the voltage code takes the new value at the start of the move, while the clock code and level keep their old values; the clock code changes exactly SETTLE_CYCLES cycles later.
- R7: On a move to a lower level, the clock code takes the new value at the start of the move, while the voltage code and level keep their old values; the voltage code changes exactly SETTLE_CYCLES cycles later.
- R8: The transition flag is high for exactly 2*SETTLE_CYCLES cycles per move. The reported level changes to the new level in the cycle the flag falls, and no other move overlaps.
- R9: While appReqEn is high, the governor moves directly to appLevel in a single move, and window decisions are ignored.
- R10: A request that arrives during a move is held and served after the move's lockout ends.
- R11: The level whose voltage is applied is never below the level whose clock is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busyIn | input | 1 | Core busy in this cycle |
| upThresh | input | CNT_W | Busy-count limit for stepping up |
| downThresh | input | CNT_W | Idle-count limit for stepping down |
| appReqEn | input | 1 | Application level request active (level-held) |
| appLevel | input | LVL_W | Requested level while appReqEn is high |
| levelIdx | output | LVL_W | Settled operating level |
| voltCode | output | VCODE_W | Voltage select to the regulator |
| clkCode | output | CCODE_W | Clock select (MHz) to the clock generator |
| transBusy | output | 1 | Move and settle lockout in progress |

## Verification
The window predictor is driven with busy patterns of period equal to the window length, so that every window holds exactly b busy cycles whatever its phase. b is swept over all values from 0 to 16 around thresholds of 9. This separates the up, down and hold decisions and catches a strict-versus-inclusive comparison at b=9 and b=7. Long runs of all-busy and all-idle windows walk the level across the whole table and then press against both ends, which tells stepping apart from saturation. Application requests visit every level in a scrambled order to check both code tables, the ordering of the two moves and the lockout length. A request changed in the middle of a move shows that it is held rather than dropped, and a held request against a fully loaded core shows its precedence over the predictor.

// File: rtl/dvs_gov_pkg.sv
package dvs_gov_pkg;

  // Sequencer state of one move
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,   // first rail changed, settling
    ST_LAST  = 2'd2    // second rail changed, lockout
  } govStateT;

  // Predictor request waiting for the sequencer
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_UP   = 2'd1,
    PEND_DN   = 2'd2
  } pendT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadVolt;   // apply target level to the voltage rail
    logic loadClk;    // apply target level to the clock
    logic commit;     // report target level as settled
  } govStbT;

endpackage

// File: rtl/dvs_gov_dp.sv
module dvs_gov_dp
  import dvs_gov_pkg::*;
#(
  parameter int NUM_LEVELS   = 8,
  parameter int LVL_W        = 3,
  parameter int VCODE_W      = 4,
  parameter int CCODE_W      = 8,
  parameter int INTERVAL_LEN = 1024,
  parameter int CNT_W        = 11,
  parameter int V_BASE       = 1,
  parameter int V_STEP       = 2,
  parameter int F_MIN        = 59,
  parameter int F_MAX        = 250,
  parameter int RESET_LEVEL  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busyIn,
  input  logic [CNT_W-1:0]   upThresh,
  input  logic [CNT_W-1:0]   downThresh,
  input  govStbT             stb,
  input  logic [LVL_W-1:0]   tgtLvl,
  output logic               evalUp,
  output logic               evalDown,
  output logic [LVL_W-1:0]   levelIdx,
  output logic [VCODE_W-1:0] voltCode,
  output logic [CCODE_W-1:0] clkCode
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INTERVAL_LEN - 1);
  localparam logic [CNT_W-1:0] WIN_LEN  = CNT_W'(INTERVAL_LEN);
  localparam logic [LVL_W-1:0] RST_LVL  = LVL_W'(RESET_LEVEL);
  localparam int               SPAN_F   = F_MAX - F_MIN;

  // ---------------- level tables, computed per entry ----------------
  logic [VCODE_W-1:0] vTab [NUM_LEVELS];
  logic [CCODE_W-1:0] cTab [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLevelTab
    assign vTab[g] = VCODE_W'(V_BASE + V_STEP * g);
    assign cTab[g] = CCODE_W'(F_MIN + (SPAN_F * g) / (NUM_LEVELS - 1));
  end

  // ---------------- observation window ----------------
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W-1:0] busyCnt;
  logic [CNT_W-1:0] busyTot;
  logic [CNT_W-1:0] idleTot;
  logic             intEnd;
  logic             overUp;

  assign intEnd  = (intCnt == LAST_CNT);
  assign busyTot = busyCnt + CNT_W'(busyIn);
  assign idleTot = WIN_LEN - busyTot;
  assign overUp  = (busyTot > upThresh);
  assign evalUp   = intEnd && overUp;
  assign evalDown = intEnd && !overUp && (idleTot > downThresh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intCnt  <= '0;
      busyCnt <= '0;
    end else if (intEnd) begin
      intCnt  <= '0;
      busyCnt <= '0;
    end else begin
      intCnt  <= intCnt + CNT_W'(1);
      busyCnt <= busyTot;
    end
  end

  // ---------------- operating point registers ----------------
  logic [LVL_W-1:0] voltLvl;
  logic [LVL_W-1:0] clkLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      voltLvl  <= RST_LVL;
      clkLvl   <= RST_LVL;
      levelIdx <= RST_LVL;
    end else begin
      if (stb.loadVolt) voltLvl  <= tgtLvl;
      if (stb.loadClk)  clkLvl   <= tgtLvl;
      if (stb.commit)   levelIdx <= tgtLvl;
    end
  end

  assign voltCode = vTab[voltLvl];
  assign clkCode  = cTab[clkLvl];

  // ---------------- checks ----------------
  // R11
  envelope_chk: assert property (@(posedge clk) disable iff (!rstN)
    voltLvl >= clkLvl);

  // R6
  one_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(voltLvl) |-> $stable(clkLvl));

  // R8
  commit_after_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelIdx) |-> (levelIdx == voltLvl && levelIdx == clkLvl));

  // R3
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    intCnt <= LAST_CNT);

endmodule

// File: rtl/dvs_gov_ctrl.sv
module dvs_gov_ctrl
  import dvs_gov_pkg::*;
#(
  parameter int NUM_LEVELS    = 8,
  parameter int LVL_W         = 3,
  parameter int SETTLE_CYCLES = 37500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalUp,
  input  logic             evalDown,
  input  logic             appReqEn,
  input  logic [LVL_W-1:0] appLevel,
  input  logic [LVL_W-1:0] levelIdx,
  output govStbT           stb,
  output logic [LVL_W-1:0] tgtLvl,
  output logic             transBusy
);

  localparam int               SET_W   = $clog2(SETTLE_CYCLES + 1);
  localparam int               LOCK_W  = $clog2(2 * SETTLE_CYCLES + 1);
  localparam logic [SET_W-1:0] SET_LD  = SET_W'(SETTLE_CYCLES - 1);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);

  govStateT         state;
  govStateT         stateNext;
  pendT             pend;
  pendT             pendNext;
  logic [SET_W-1:0] settleCnt;
  logic [LVL_W-1:0] tgtReg;
  logic             upReg;

  logic [LVL_W-1:0] appClamp;
  logic [LVL_W-1:0] newTgt;
  logic             launch;
  logic             goUp;
  logic             isIdle;
  logic             settleDone;

  assign isIdle     = (state == ST_IDLE);
  assign settleDone = (settleCnt == '0);
  assign appClamp   = (appLevel > TOP_LVL) ? TOP_LVL : appLevel;

  // Pick the next target: application request first, then predictor
  always_comb begin
    launch = 1'b0;
    newTgt = levelIdx;
    if (appReqEn) begin
      newTgt = appClamp;
      launch = (appClamp != levelIdx);
    end else if (pend == PEND_UP && levelIdx != TOP_LVL) begin
      newTgt = levelIdx + LVL_W'(1);
      launch = 1'b1;
    end else if (pend == PEND_DN && levelIdx != '0) begin
      newTgt = levelIdx - LVL_W'(1);
      launch = 1'b1;
    end
    goUp = (newTgt > levelIdx);
  end

  // Strobes and next state
  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (launch) begin
          stb.loadVolt = goUp;
          stb.loadClk  = !goUp;
          stateNext    = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (settleDone) begin
          stb.loadVolt = !upReg;
          stb.loadClk  = upReg;
          stateNext    = ST_LAST;
        end
      end
      ST_LAST: begin
        if (settleDone) begin
          stb.commit = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign tgtLvl    = isIdle ? newTgt : tgtReg;
  assign transBusy = !isIdle;

  // Predictor request slot: newest window decision wins, held while busy
  always_comb begin
    if (appReqEn)      pendNext = PEND_NONE;
    else if (evalUp)   pendNext = PEND_UP;
    else if (evalDown) pendNext = PEND_DN;
    else if (isIdle)   pendNext = PEND_NONE;
    else               pendNext = pend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pend      <= PEND_NONE;
      settleCnt <= '0;
      tgtReg    <= '0;
      upReg     <= 1'b0;
    end else begin
      state <= stateNext;
      pend  <= pendNext;
      if (isIdle && launch) begin
        tgtReg    <= newTgt;
        upReg     <= goUp;
        settleCnt <= SET_LD;
      end else if (!isIdle && settleDone) begin
        settleCnt <= SET_LD;
      end else if (!isIdle) begin
        settleCnt <= settleCnt - SET_W'(1);
      end
    end
  end

  // ---------------- checks ----------------
  logic [LOCK_W-1:0] lockCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       lockCnt <= '0;
    else if (isIdle) lockCnt <= '0;
    else             lockCnt <= lockCnt + LOCK_W'(1);
  end

  // R8
  lockout_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && $past(state) != ST_IDLE) |-> (lockCnt == LOCK_W'(2 * SETTLE_CYCLES)));

  // R9
  app_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && appReqEn && appClamp == levelIdx) |=> isIdle);

  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && !appReqEn && pend == PEND_UP && levelIdx == TOP_LVL) |=> isIdle);

endmodule

// File: rtl/dvs_governor.sv
module dvs_governor
  import dvs_gov_pkg::*;
#(
  parameter int NUM_LEVELS    = 8,
  parameter int VCODE_W       = 4,
  parameter int CCODE_W       = 8,
  parameter int INTERVAL_LEN  = 1024,
  parameter int SETTLE_CYCLES = 37500,
  parameter int V_BASE        = 1,
  parameter int V_STEP        = 2,
  parameter int F_MIN         = 59,
  parameter int F_MAX         = 250,
  parameter int RESET_LEVEL   = 0,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int CNT_W        = $clog2(INTERVAL_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busyIn,
  input  logic [CNT_W-1:0]   upThresh,
  input  logic [CNT_W-1:0]   downThresh,
  input  logic               appReqEn,
  input  logic [LVL_W-1:0]   appLevel,
  output logic [LVL_W-1:0]   levelIdx,
  output logic [VCODE_W-1:0] voltCode,
  output logic [CCODE_W-1:0] clkCode,
  output logic               transBusy
);

  govStbT           stb;
  logic [LVL_W-1:0] tgtLvl;
  logic             evalUp;
  logic             evalDown;

  dvs_gov_ctrl #(
    .NUM_LEVELS   (NUM_LEVELS),
    .LVL_W        (LVL_W),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .evalUp   (evalUp),
    .evalDown (evalDown),
    .appReqEn (appReqEn),
    .appLevel (appLevel),
    .levelIdx (levelIdx),
    .stb      (stb),
    .tgtLvl   (tgtLvl),
    .transBusy(transBusy)
  );

  dvs_gov_dp #(
    .NUM_LEVELS  (NUM_LEVELS),
    .LVL_W       (LVL_W),
    .VCODE_W     (VCODE_W),
    .CCODE_W     (CCODE_W),
    .INTERVAL_LEN(INTERVAL_LEN),
    .CNT_W       (CNT_W),
    .V_BASE      (V_BASE),
    .V_STEP      (V_STEP),
    .F_MIN       (F_MIN),
    .F_MAX       (F_MAX),
    .RESET_LEVEL (RESET_LEVEL)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .busyIn    (busyIn),
    .upThresh  (upThresh),
    .downThresh(downThresh),
    .stb       (stb),
    .tgtLvl    (tgtLvl),
    .evalUp    (evalUp),
    .evalDown  (evalDown),
    .levelIdx  (levelIdx),
    .voltCode  (voltCode),
    .clkCode   (clkCode)
  );

endmodule

// File: tb/tb_dvs_governor.sv
`timescale 1ns/1ps
module tb_dvs_governor;

  localparam int WIN    = 16;
  localparam int SETTLE = 4;
  localparam int CW     = $clog2(WIN + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busyIn = 1'b0;
  logic [CW-1:0] upThresh = CW'(10);
  logic [CW-1:0] downThresh = CW'(10);
  logic          appReqEn = 1'b0;
  logic [2:0]    appLevel = 3'd0;
  logic [2:0]    levelIdx;
  logic [3:0]    voltCode;
  logic [7:0]    clkCode;
  logic          transBusy;

  int nChecks = 0;
  int nFails  = 0;
  int busyCount = 8;
  int phase = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dvs_governor #(.INTERVAL_LEN(WIN), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .upThresh(upThresh),
    .downThresh(downThresh), .appReqEn(appReqEn), .appLevel(appLevel),
    .levelIdx(levelIdx), .voltCode(voltCode), .clkCode(clkCode),
    .transBusy(transBusy));

  // Busy pattern with period WIN: every window holds busyCount busy cycles
  always @(negedge clk) begin
    busyIn <= (phase < busyCount);
    phase  <= (phase == WIN - 1) ? 0 : phase + 1;
  end

  function automatic int expV(int l); return 1 + 2 * l; endfunction
  function automatic int expC(int l); return 59 + (191 * l) / 7; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 60000 && !done) begin
        nFails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 60000);
        summary();
        $finish;
      end
    end
  end

  // Observe one move from oldL to newL; optionally change appLevel mid-move
  task automatic runTrans(int oldL, int newL, int midLvl);
    int t = 0;
    int k = 0;
    bit up = (newL > oldL);
    do begin @(negedge clk); t++; end while (!transBusy && t < 60);
    chk(transBusy, "R8 move start", int'(transBusy), 1);
    if (!transBusy) return;
    while (transBusy && k < 100) begin
      if (k == 0) begin
        chk(levelIdx == oldL, "R8 level held during move", levelIdx, oldL);
        if (up) begin
          chk(voltCode == expV(newL), "R6 voltage first", voltCode, expV(newL));
          chk(clkCode == expC(oldL), "R6 clock still old", clkCode, expC(oldL));
        end else begin
          chk(clkCode == expC(newL), "R7 clock first", clkCode, expC(newL));
          chk(voltCode == expV(oldL), "R7 voltage still old", voltCode, expV(oldL));
        end
      end
      if (k == 2 && midLvl >= 0) appLevel = 3'(midLvl);
      if (k == SETTLE - 1) begin
        if (up) chk(clkCode == expC(oldL), "R6 clock waits settle", clkCode, expC(oldL));
        else    chk(voltCode == expV(oldL), "R7 voltage waits settle", voltCode, expV(oldL));
      end
      if (k == SETTLE) begin
        if (up) chk(clkCode == expC(newL), "R6 clock after settle", clkCode, expC(newL));
        else    chk(voltCode == expV(newL), "R7 voltage after settle", voltCode, expV(newL));
      end
      k++;
      @(negedge clk);
    end
    chk(k == 2 * SETTLE, "R8 lockout length", k, 2 * SETTLE);
    chk(levelIdx == newL, "R8 level at end of move", levelIdx, newL);
    chk(voltCode == expV(newL), "R2 voltage code", voltCode, expV(newL));
    chk(clkCode == expC(newL), "R2 clock code", clkCode, expC(newL));
  endtask

  // No move may start during n cycles
  task automatic quiet(int n, int expL, string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (transBusy) seen = 1;
    end
    chk(!seen, tag, int'(seen), 0);
    chk(levelIdx == expL, tag, levelIdx, expL);
  endtask

  initial begin
    int curL;
    int expL;
    int order [8] = '{7, 0, 4, 1, 6, 2, 5, 3};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(levelIdx == 0 && !transBusy, "R1 in reset level/flag", levelIdx, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(levelIdx == 0, "R1 level", levelIdx, 0);
    chk(voltCode == 1, "R1 voltage code", voltCode, 1);
    chk(clkCode == 59, "R1 clock code", clkCode, 59);
    chk(!transBusy, "R1 flag", int'(transBusy), 0);

    // R4 hold band: 8 busy, 8 idle, both limits 10
    quiet(48, 0, "R4 hold band");

    // R5 floor: all idle at level 0
    busyCount = 0;
    quiet(48, 0, "R5 no step below 0");

    // R3 stepping up through the table
    busyCount = WIN;
    for (int l = 0; l < 7; l++) runTrans(l, l + 1, -1);
    quiet(48, 7, "R5 no step above 7");

    // R4 stepping down
    busyCount = 0;
    for (int l = 7; l > 0; l--) runTrans(l, l - 1, -1);

    // R9 application moves visiting every level (R2 codes)
    busyCount = 8;
    curL = 0;
    appReqEn = 1'b1;
    foreach (order[i]) begin
      appLevel = 3'(order[i]);
      runTrans(curL, order[i], -1);
      curL = order[i];
    end

    // R9 precedence over a fully loaded predictor
    busyCount = WIN;
    quiet(48, 3, "R9 predictor ignored");

    // R10 request changed mid-move is held
    busyCount = 8;
    appLevel = 3'd6;
    runTrans(3, 6, 1);
    runTrans(6, 1, -1);
    curL = 1;
    appReqEn = 1'b0;
    quiet(40, 1, "R10 no extra move");

    // R3/R4 sweep of busy count against limits of 9
    upThresh = CW'(9);
    downThresh = CW'(9);
    for (int b = 0; b <= WIN; b++) begin
      appReqEn = 1'b1;
      appLevel = 3'd4;
      busyCount = b;
      if (curL != 4) runTrans(curL, 4, -1);
      repeat (20) @(negedge clk);
      appReqEn = 1'b0;
      if (b > 9)            expL = 5;
      else if (WIN - b > 9) expL = 3;
      else                  expL = 4;
      if (expL == 4) begin
        quiet(40, 4, $sformatf("R4 hold at b=%0d", b));
      end else begin
        runTrans(4, expL, -1);
        chk(levelIdx == expL, $sformatf("R3 decision at b=%0d", b), levelIdx, expL);
      end
      curL = expL;
      appReqEn = 1'b1;
      appLevel = 3'd4;
    end

    done = 1;
    summary();
    $finish;
  end

endmodule